// File: doc/BRIEF.md
# Single-Operand Subtract-and-Skip Processor Core

This block is a tiny processor with exactly one instruction. Every program word is an operand address and nothing else. Executing a word at address X takes the word stored at X and subtracts the internal accumulator from it. The difference is written back to X and is also copied into the accumulator. When the subtraction borrows, the next program word is skipped.

Control flow comes from a few low addresses that are mapped onto core state rather than onto memory:

- Address 0 is the program counter. Writing a result there makes an indirect jump.
- Address 1 is the accumulator.
- Address 3 is a write-only output port.
- Address 4 stops the core.

One parameter sets both the word width and the address width, because every word has to be able to name any other word. The reference configuration is 32 bits.

The core drives a single-port synchronous memory. The address is presented in one cycle and the read data returns on the next. The core makes at most one access per cycle. It also reports a count of completed instructions, so a bench can compare a run against a model.

Top module: `rssb_core`

## Requirements
- R1: A synchronous reset sets the program counter to 5 and clears the accumulator, the instruction count, `outValid` and `halted`. In the first cycle after reset, `memAddr` shows 5 and `memWe` is low.
- R2: Each instruction takes exactly three cycles, with one memory access in each:
  - fetch the operand X from the program counter address;
  - read the word at X;
  - write back and update the program counter.
  A program that halts on its fifth instruction shows `halted` 15 cycles after reset is released.
- R3: The result is (word at X) minus accumulator, modulo 2^WORD_W. It is stored both at X and in the accumulator.
- R4: A borrow occurs when the accumulator is greater than the word at X, compared unsigned. On a borrow the program counter advances by 2; otherwise it advances by 1. Equal values do not borrow.
- R5: Read as an operand, address 0 returns the address of the instruction now executing. When X is 0, the result is loaded into the program counter and neither the increment nor the skip is applied.
- R6: Address 1 reads as the accumulator. A write to it leaves the accumulator equal to the result.
- R7: A write to address 3 places the result on `outData` and pulses `outValid` high for exactly one cycle. Reading address 3 returns 0.
- R8: A write to address 4 sets `halted`, and it stays set until reset. While halted, no memory writes occur and the instruction count does not change. Reading address 4 returns 0.
- R9: Addresses 0 to 4 are never written to the external memory, so `memWe` is never high with `memAddr` below 5.
- R10: `retired` increases by exactly one for each completed instruction, including the one that halts the core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | WORD_W | Memory word address |
| memWe | output | 1 | Memory write enable |
| memWdata | output | WORD_W | Memory write data |
| memRdata | input | WORD_W | Memory read data, valid the cycle after the address |
| outData | output | WORD_W | Last value written to the output port |
| outValid | output | 1 | One-cycle strobe for each output port write |
| halted | output | 1 | Core has stopped |
| retired | output | CNT_W | Completed instruction count |

## Verification
The assertions check the following on every cycle:

- `halted` stays set once it is set, and memory stays quiet while halted.
- No write ever reaches a mapped address.
- The output strobe lasts a single cycle.
- The instruction count only ever steps by one.
- A borrowing instruction moves the program counter by two.
- A write to address 0 loads the program counter with the computed difference.

Only the bench's directed programs can show that the arithmetic runs in the reversed direction and that equal values do not skip. They also show that mapped reads return the program counter, the accumulator and zero, and that whole programs take the expected path with the expected cycle count.

// File: rtl/rssb_pkg.sv
package rssb_pkg;

  typedef enum logic [1:0] {
    PH_FETCH,
    PH_READ,
    PH_WRITE,
    PH_HALT
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic read;   // operand arrives, data address driven
    logic write;  // result committed
  } strobe_t;

  localparam int unsigned MAP_PC   = 0;
  localparam int unsigned MAP_ACC  = 1;
  localparam int unsigned MAP_OUT  = 3;
  localparam int unsigned MAP_HALT = 4;
  localparam int unsigned RESET_PC = 5;  // also the first ordinary memory word

endpackage

// File: rtl/rssb_ctrl.sv
module rssb_ctrl
  import rssb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    haltReq,
  output strobe_t strobe,
  output logic    halted
);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
    end else begin
      case (phase)
        PH_FETCH: phase <= PH_READ;
        PH_READ:  phase <= PH_WRITE;
        PH_WRITE: phase <= haltReq ? PH_HALT : PH_FETCH;
        default:  phase <= PH_HALT;
      endcase
    end
  end

  always_comb begin
    strobe.read  = (phase == PH_READ);
    strobe.write = (phase == PH_WRITE);
    halted       = (phase == PH_HALT);
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R8

endmodule

// File: rtl/rssb_datapath.sv
module rssb_datapath
  import rssb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic              memWe,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic [CNT_W-1:0]  retired,
  output logic              haltReq
);

  localparam logic [WORD_W-1:0] A_PC    = WORD_W'(MAP_PC);
  localparam logic [WORD_W-1:0] A_ACC   = WORD_W'(MAP_ACC);
  localparam logic [WORD_W-1:0] A_OUT   = WORD_W'(MAP_OUT);
  localparam logic [WORD_W-1:0] A_HALT  = WORD_W'(MAP_HALT);
  localparam logic [WORD_W-1:0] A_START = WORD_W'(RESET_PC);

  logic [WORD_W-1:0] pc, acc, opReg;
  logic [WORD_W-1:0] fetchWord, srcVal, diff;
  logic              borrow, opMapped;
  logic              pastOk;

  // Mapped view of a word: core state for the low addresses, memory elsewhere
  function automatic logic [WORD_W-1:0] mapRead(
    input logic [WORD_W-1:0] addr,
    input logic [WORD_W-1:0] raw,
    input logic [WORD_W-1:0] pcNow,
    input logic [WORD_W-1:0] accNow
  );
    if (addr == A_PC)                        return pcNow;
    else if (addr == A_ACC)                  return accNow;
    else if (addr == A_OUT || addr == A_HALT) return '0;
    else                                      return raw;
  endfunction

  always_comb begin
    fetchWord = mapRead(pc, memRdata, pc, acc);
    srcVal    = mapRead(opReg, memRdata, pc, acc);
    diff      = srcVal - acc;
    borrow    = acc > srcVal;
    opMapped  = opReg < A_START;
    if (strobe.read)       memAddr = fetchWord;
    else if (strobe.write) memAddr = opReg;
    else                   memAddr = pc;
    memWe    = strobe.write && !opMapped;
    memWdata = diff;
    haltReq  = strobe.write && (opReg == A_HALT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= A_START;
      acc      <= '0;
      opReg    <= '0;
      outData  <= '0;
      outValid <= 1'b0;
      retired  <= '0;
      pastOk   <= 1'b0;
    end else begin
      pastOk   <= 1'b1;
      outValid <= 1'b0;
      if (strobe.read) opReg <= fetchWord;
      if (strobe.write) begin
        acc     <= diff;
        retired <= retired + CNT_W'(1);
        if (opReg == A_PC) pc <= diff;
        else               pc <= pc + (borrow ? WORD_W'(2) : WORD_W'(1));
        if (opReg == A_OUT) begin
          outData  <= diff;
          outValid <= 1'b1;
        end
      end
    end
  end

  AST_MAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    memWe |-> memAddr >= A_START); // R9

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid); // R7

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    (pastOk && retired != $past(retired)) |-> retired == $past(retired) + CNT_W'(1)); // R10

  AST_SKIP_ON_BORROW: assert property (@(posedge clk) disable iff (rst)
    (strobe.write && opReg != A_PC && borrow) |=> pc == $past(pc) + WORD_W'(2)); // R4

  AST_PC_JUMP: assert property (@(posedge clk) disable iff (rst)
    (strobe.write && opReg == A_PC) |=> pc == $past(diff)); // R5

endmodule

// File: rtl/rssb_core.sv
module rssb_core
  import rssb_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] memAddr,
  output logic              memWe,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              halted,
  output logic [CNT_W-1:0]  retired
);

  strobe_t strobe;
  logic    haltReq;

  rssb_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .haltReq(haltReq),
    .strobe (strobe),
    .halted (halted)
  );

  rssb_datapath #(
    .WORD_W(WORD_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWe   (memWe),
    .memWdata(memWdata),
    .outData (outData),
    .outValid(outValid),
    .retired (retired),
    .haltReq (haltReq)
  );

  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> !memWe); // R8

endmodule

// File: tb/rssb_core_bench.sv
module rssb_core_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] memAddr, memWdata, memRdata, outData;
  logic         memWe, outValid, halted;
  logic [31:0]  retired;

  logic [W-1:0] mem [0:63];
  logic [W-1:0] outLog [0:7];
  int           outCount = 0;
  int           errors = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rssb_core #(.WORD_W(W), .CNT_W(32)) u_rssb_core (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .outData(outData), .outValid(outValid),
    .halted(halted), .retired(retired)
  );

  // Single-port synchronous memory model
  always @(posedge clk) begin
    memRdata <= mem[memAddr[5:0]];
    if (memWe === 1'b1) mem[memAddr[5:0]] <= memWdata;
  end

  always @(negedge clk) begin
    if (!rst && outValid === 1'b1 && outCount < 8) begin
      outLog[outCount] = outData;
      outCount = outCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0] = 32'hAA;
    mem[1] = 32'hBB;
    mem[3] = 32'h55;
    mem[4] = 32'h66;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    outCount = 0;
    rst = 1'b0;
  endtask

  task automatic runToHalt(output int cycles);
    cycles = 0;
    while (halted !== 1'b1 && cycles < 400) begin
      @(negedge clk);
      cycles = cycles + 1;
    end
  endtask

  task automatic testReset();
    clearMem();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(memAddr == 32'd5, "R1 fetch address in reset", memAddr, 32'd5);
    check(memWe == 1'b0, "R1 no write in reset", {31'b0, memWe}, 0);
    check(halted == 1'b0, "R1 not halted", {31'b0, halted}, 0);
    check(retired == 0, "R1 count cleared", retired, 0);
    check(outValid == 1'b0, "R1 no output strobe", {31'b0, outValid}, 0);
  endtask

  // Borrows, skips, output port, halt, cycle count
  task automatic testSkipChain();
    int cyc;
    clearMem();
    mem[5] = 20; mem[6] = 3; mem[7] = 4; mem[8] = 21; mem[9] = 4;
    mem[10] = 3; mem[11] = 4; mem[12] = 4;
    mem[20] = 7; mem[21] = 0;
    doReset();
    runToHalt(cyc);
    check(cyc == 15, "R2 cycles to halt", cyc, 15);
    check(retired == 5, "R10 retired at halt", retired, 5);
    check(outCount == 2, "R7 output count", outCount, 2);
    check(outLog[0] == 32'hFFFF_FFF9, "R3 first output", outLog[0], 32'hFFFF_FFF9);
    check(outLog[1] == 32'hFFFF_FFF9, "R7 reread of out port is 0", outLog[1], 32'hFFFF_FFF9);
    check(mem[20] == 7, "R3 result stored", mem[20], 7);
    check(mem[21] == 7, "R4 borrow result stored", mem[21], 7);
  endtask

  task automatic testHaltHold();
    int r0;
    bit sawWe;
    r0 = retired;
    sawWe = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (memWe) sawWe = 1'b1;
    end
    check(halted == 1'b1, "R8 halt held", {31'b0, halted}, 1);
    check(sawWe == 1'b0, "R8 no write while halted", {31'b0, sawWe}, 0);
    check(retired == r0, "R8 count frozen", retired, r0);
    check(mem[3] == 32'h55, "R9 out port not in memory", mem[3], 32'h55);
    check(mem[4] == 32'h66, "R9 halt word not in memory", mem[4], 32'h66);
  endtask

  task automatic testEqualNoSkip();
    int cyc;
    clearMem();
    mem[5] = 20; mem[6] = 21; mem[7] = 4; mem[8] = 3; mem[9] = 4;
    mem[20] = 9; mem[21] = 9;
    doReset();
    runToHalt(cyc);
    check(retired == 3, "R4 equal does not skip", retired, 3);
    check(outCount == 0, "R4 no stray output", outCount, 0);
    check(mem[21] == 0, "R3 equal difference", mem[21], 0);
  endtask

  task automatic testJump();
    int cyc;
    clearMem();
    mem[5] = 20; mem[6] = 0; mem[7] = 4; mem[8] = 4;
    mem[29] = 3; mem[30] = 4; mem[31] = 4;
    mem[20] = 32'hFFFF_FFE9;
    doReset();
    runToHalt(cyc);
    check(retired == 4, "R5 jump path length", retired, 4);
    check(outCount == 1, "R5 output after jump", outCount, 1);
    check(outLog[0] == 32'hFFFF_FFE3, "R5 acc after jump", outLog[0], 32'hFFFF_FFE3);
    check(mem[0] == 32'hAA, "R9 pc write not in memory", mem[0], 32'hAA);
  endtask

  task automatic testAccAlias();
    int cyc;
    clearMem();
    mem[5] = 20; mem[6] = 1; mem[7] = 21; mem[8] = 3; mem[9] = 3; mem[10] = 4;
    mem[20] = 5; mem[21] = 3;
    doReset();
    runToHalt(cyc);
    check(retired == 5, "R6 accumulator alias path", retired, 5);
    check(outCount == 1, "R6 single output", outCount, 1);
    check(outLog[0] == 32'hFFFF_FFFD, "R6 output value", outLog[0], 32'hFFFF_FFFD);
    check(mem[1] == 32'hBB, "R9 acc write not in memory", mem[1], 32'hBB);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testSkipChain();
    testHaltHold();
    testEqualNoSkip();
    testJump();
    testAccAlias();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule